// File: doc/BRIEF.md
# Parallel CRC Update Unit

This block advances a CRC register by a whole data word in each clock cycle. A combinational folding core takes the present CRC state and a DATA_W-bit word and produces the state that DATA_W single-bit shift-register steps would reach. The polynomial, the CRC width, the word width and the shift direction are all fixed at elaboration time. A registered wrapper holds the running state. The wrapper can be reloaded with a seed value, and it takes one word on every cycle in which its valid strobe is high.

Two shift directions are offered. In the left-shifting form the word is consumed from its top bit down, and feedback is taken from the CRC MSB. In the reflected right-shifting form the word is consumed from bit 0 up, and feedback is taken from the CRC LSB. Any final inversion, output bit reversal or residue comparison is done by the logic around the block.

Top module: `crc_par_unit`

## Requirements
- R1: CRC_W and DATA_W are independent parameters, and each may be as small as 1. If either is set below 1, elaboration stops with an error.
- R2: With DIR = CRC_SHL, the core output equals DATA_W serial steps applied to the input state. Data bit DATA_W-1 is used first and bit 0 last. In each step the feedback is state[CRC_W-1] XOR the data bit, the state shifts one place toward its MSB, and a 0 enters bit 0.
- R3: With DIR = CRC_SHR, the core output equals DATA_W serial steps applied to the input state. Data bit 0 is used first. In each step the feedback is state[0] XOR the data bit, the state shifts one place toward its LSB, and a 0 enters bit CRC_W-1.
- R4: After each shift, bit j of the state is inverted when the feedback is 1 and bit j of POLY is 1. POLY omits the x^CRC_W term. In the right-shifting form POLY is given bit-reversed, for example 0xEDB88320 for the usual 32-bit code and 0x1021 for the left-shifting 16-bit code.
- R5: While rst is high at a clock edge, the register is set to INIT. crc_o shows INIT once reset is released.
- R6: When init_i is high at a clock edge, the register takes INIT, even if valid_i is also high in that cycle.
- R7: When init_i and valid_i are both low at a clock edge, crc_o keeps its value.
- R8: When valid_i is high and init_i is low at a clock edge, the register takes the core result of the present crc_o and data_i. A zero state folded with a zero word stays zero.
- R9: crc_o is the raw register contents, with no final XOR and no reflection. With the reflected 32-bit code and seed 0xFFFFFFFF, the bytes "123456789" leave 0x340BC6D9, whose inversion is 0xCBF43926.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high; loads INIT |
| init_i | input | 1 | Reload strobe; loads INIT, wins over valid_i |
| valid_i | input | 1 | Fold data_i into the state this cycle |
| data_i | input | DATA_W | Data word to fold |
| crc_o | output | CRC_W | Raw CRC register |

## Verification
The checker assumes that init_i, valid_i and data_i are never unknown at a clock edge outside reset. It also assumes that reset is applied from time zero, so that the first fall of rst marks a defined INIT state.

The bench drives every input at the falling edge from fully defined values, which come from a fixed-seed generator or from constant message bytes. It keeps rst high from the first edge. Several combinational cores with small and large widths, in both directions, are compared against a bit-serial loop model.

// File: rtl/crc_pkg.sv
package crc_pkg;

    // Shift direction of the folding core
    typedef enum logic {
        CRC_SHL = 1'b0,   // MSB-first, left shifting
        CRC_SHR = 1'b1    // reflected, LSB-first, right shifting
    } crc_dir_e;

    // What the state register does at the next edge
    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_LOAD = 2'd1,
        ACT_STEP = 2'd2
    } crc_act_e;

    // Reset and reload share the load path; a reload wins over a data beat.
    function automatic crc_act_e crc_pick_action(logic rst, logic init, logic valid);
        if (rst || init) return ACT_LOAD;
        if (valid)       return ACT_STEP;
        return ACT_HOLD;
    endfunction

endpackage

// File: rtl/crc_fold_core.sv
module crc_fold_core #(
    parameter int                 CRC_W  = 32,
    parameter int                 DATA_W = 8,
    parameter logic [CRC_W-1:0]   POLY   = 32'hEDB88320,
    parameter crc_pkg::crc_dir_e  DIR    = crc_pkg::CRC_SHR
) (
    input  logic [CRC_W-1:0]  crc_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [CRC_W-1:0]  crc_o
);
    // R1: reject degenerate widths at elaboration
    if (CRC_W < 1 || DATA_W < 1) begin : g_bad_width
        $fatal(1, "crc_fold_core: CRC_W and DATA_W must both be at least 1");
    end

    // Feedback mask applied after every single-bit shift (R4)
    localparam logic [CRC_W-1:0] FB_MASK = POLY;

    if (DIR == crc_pkg::CRC_SHL) begin : g_left
        // R2: consume data from the top bit down, feedback from the MSB
        always_comb begin
            logic [CRC_W-1:0] st;
            logic             fb;
            st = crc_i;
            for (int i = 0; i < DATA_W; i++) begin
                fb = st[CRC_W-1] ^ data_i[DATA_W-1-i];
                st = st << 1;
                st = st ^ (FB_MASK & {CRC_W{fb}});
            end
            crc_o = st;
        end
    end else begin : g_right
        // R3: consume data from bit 0 up, feedback from the LSB
        always_comb begin
            logic [CRC_W-1:0] st;
            logic             fb;
            st = crc_i;
            for (int i = 0; i < DATA_W; i++) begin
                fb = st[0] ^ data_i[i];
                st = st >> 1;
                st = st ^ (FB_MASK & {CRC_W{fb}});
            end
            crc_o = st;
        end
    end

endmodule

// File: rtl/crc_state_reg.sv
module crc_state_reg #(
    parameter int               CRC_W = 32,
    parameter logic [CRC_W-1:0] INIT  = '1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              init_i,
    input  logic              valid_i,
    input  logic [CRC_W-1:0]  next_i,
    output logic [CRC_W-1:0]  state_o
);
    import crc_pkg::*;

    crc_act_e act;

    always_comb act = crc_pick_action(rst, init_i, valid_i);

    always_ff @(posedge clk) begin
        unique case (act)
            ACT_LOAD: state_o <= INIT;      // R5, R6
            ACT_STEP: state_o <= next_i;    // R8
            default:  state_o <= state_o;   // R7
        endcase
    end

endmodule

// File: rtl/crc_par_unit.sv
module crc_par_unit #(
    parameter int                 CRC_W  = 32,
    parameter int                 DATA_W = 8,
    parameter logic [CRC_W-1:0]   POLY   = 32'hEDB88320,
    parameter logic [CRC_W-1:0]   INIT   = '1,
    parameter crc_pkg::crc_dir_e  DIR    = crc_pkg::CRC_SHR
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              init_i,
    input  logic              valid_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [CRC_W-1:0]  crc_o
);
    logic [CRC_W-1:0] fold_next;
    logic [CRC_W-1:0] state_q;

    crc_fold_core #(
        .CRC_W (CRC_W),
        .DATA_W(DATA_W),
        .POLY  (POLY),
        .DIR   (DIR)
    ) u_core (
        .crc_i (state_q),
        .data_i(data_i),
        .crc_o (fold_next)
    );

    crc_state_reg #(
        .CRC_W(CRC_W),
        .INIT (INIT)
    ) u_state (
        .clk    (clk),
        .rst    (rst),
        .init_i (init_i),
        .valid_i(valid_i),
        .next_i (fold_next),
        .state_o(state_q)
    );

    // R9: raw register, nothing applied on the way out
    assign crc_o = state_q;

endmodule

module crc_par_unit_chk #(
    parameter int               CRC_W  = 32,
    parameter int               DATA_W = 8,
    parameter logic [CRC_W-1:0] INIT   = '1
) (
    input logic              clk,
    input logic              rst,
    input logic              init_i,
    input logic              valid_i,
    input logic [DATA_W-1:0] data_i,
    input logic [CRC_W-1:0]  crc_o
);
    p_reset_init_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> crc_o == INIT);

    p_init_load_r6: assert property (@(posedge clk) disable iff (rst)
        init_i |=> crc_o == INIT);

    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!init_i && !valid_i) |=> $stable(crc_o));

    p_zero_keep_r8: assert property (@(posedge clk) disable iff (rst)
        (valid_i && !init_i && crc_o == '0 && data_i == '0) |=> crc_o == '0);

    p_known_ctrl_r8: assert property (@(posedge clk) disable iff (rst)
        !$isunknown({init_i, valid_i}));

endmodule

bind crc_par_unit crc_par_unit_chk #(
    .CRC_W (CRC_W),
    .DATA_W(DATA_W),
    .INIT  (INIT)
) u_chk (
    .clk    (clk),
    .rst    (rst),
    .init_i (init_i),
    .valid_i(valid_i),
    .data_i (data_i),
    .crc_o  (crc_o)
);

// File: tb/crc_par_unit_tb.sv
module crc_par_unit_tb;
    import crc_pkg::*;

    localparam int          D_CRC  = 32;
    localparam int          D_DATA = 8;
    localparam logic [31:0] D_POLY = 32'hEDB88320;
    localparam logic [31:0] D_INIT = 32'hFFFFFFFF;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              init_i = 1'b0;
    logic              valid_i = 1'b0;
    logic [D_DATA-1:0] data_i = '0;
    logic [D_CRC-1:0]  crc_o;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #10 clk = ~clk;   // 50 MHz

    crc_par_unit #(
        .CRC_W(D_CRC), .DATA_W(D_DATA), .POLY(D_POLY), .INIT(D_INIT), .DIR(CRC_SHR)
    ) u_dut (
        .clk(clk), .rst(rst), .init_i(init_i), .valid_i(valid_i),
        .data_i(data_i), .crc_o(crc_o)
    );

    // Stand-alone cores, shared stimulus slices
    logic [31:0] cin = '0;
    logic [31:0] din = '0;
    logic [7:0]  o_l8;
    logic [15:0] o_l16;
    logic [31:0] o_l32;
    logic [7:0]  o_r8;
    logic [15:0] o_r16;
    logic [31:0] o_r32;

    crc_fold_core #(.CRC_W(8),  .DATA_W(1),  .POLY(8'h07),         .DIR(CRC_SHL))
        u_l8  (.crc_i(cin[7:0]),  .data_i(din[0]),    .crc_o(o_l8));
    crc_fold_core #(.CRC_W(16), .DATA_W(8),  .POLY(16'h1021),      .DIR(CRC_SHL))
        u_l16 (.crc_i(cin[15:0]), .data_i(din[7:0]),  .crc_o(o_l16));
    crc_fold_core #(.CRC_W(32), .DATA_W(32), .POLY(32'h04C11DB7),  .DIR(CRC_SHL))
        u_l32 (.crc_i(cin),       .data_i(din),       .crc_o(o_l32));
    crc_fold_core #(.CRC_W(8),  .DATA_W(32), .POLY(8'h8C),         .DIR(CRC_SHR))
        u_r8  (.crc_i(cin[7:0]),  .data_i(din),       .crc_o(o_r8));
    crc_fold_core #(.CRC_W(16), .DATA_W(1),  .POLY(16'h8408),      .DIR(CRC_SHR))
        u_r16 (.crc_i(cin[15:0]), .data_i(din[0]),    .crc_o(o_r16));
    crc_fold_core #(.CRC_W(32), .DATA_W(32), .POLY(32'hEDB88320),  .DIR(CRC_SHR))
        u_r32 (.crc_i(cin),       .data_i(din),       .crc_o(o_r32));

    // Bit-serial reference, one shift per loop pass
    function automatic logic [31:0] ref_serial(int cw, int dw, logic [31:0] poly,
                                               bit right, logic [31:0] crc,
                                               logic [31:0] data);
        logic [31:0] mask;
        logic [31:0] s;
        mask = (cw == 32) ? 32'hFFFFFFFF : ((32'd1 << cw) - 32'd1);
        s = crc & mask;
        for (int i = 0; i < dw; i++) begin
            bit fb;
            if (right) begin
                fb = s[0] ^ data[i];
                s  = s >> 1;
            end else begin
                fb = s[cw-1] ^ data[dw-1-i];
                s  = (s << 1) & mask;
            end
            if (fb) s = s ^ poly;
        end
        return s & mask;
    endfunction

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %08h expected %08h", req, got, exp);
        end
    endtask

    // Scoreboard for the registered unit
    logic [31:0] exp_q[$];
    logic [31:0] model = D_INIT;
    bit drv_beat = 0;
    bit mon_pend = 0;

    task automatic beat(bit ini, bit vld, logic [7:0] d);
        @(negedge clk);
        init_i  = ini;
        valid_i = vld;
        data_i  = d;
        drv_beat = 1;
        if (ini)      model = D_INIT;
        else if (vld) model = ref_serial(32, 8, D_POLY, 1, model, {24'd0, d});
        exp_q.push_back(model);
    endtask

    always @(posedge clk) mon_pend <= drv_beat;

    always @(negedge clk) begin
        if (mon_pend) begin
            if (exp_q.size() == 0) begin
                chk("R8 (scoreboard empty)", crc_o, 32'hx);
            end else begin
                logic [31:0] e;
                e = exp_q.pop_front();
                chk("R6/R7/R8 register beat", crc_o, e);
            end
        end
    end

    task automatic core_round(logic [31:0] c, logic [31:0] d);
        cin = c;
        din = d;
        #1;
        chk("R1 R2 left CRC-8 DATA_W=1",   {24'd0, o_l8},  ref_serial(8, 1, 32'h07, 0, c, d));
        chk("R2 left CRC-16 DATA_W=8",     {16'd0, o_l16}, ref_serial(16, 8, 32'h1021, 0, c, d));
        chk("R2 left CRC-32 DATA_W=32",    o_l32,          ref_serial(32, 32, 32'h04C11DB7, 0, c, d));
        chk("R3 right CRC-8 DATA_W=32",    {24'd0, o_r8},  ref_serial(8, 32, 32'h8C, 1, c, d));
        chk("R1 R3 right CRC-16 DATA_W=1", {16'd0, o_r16}, ref_serial(16, 1, 32'h8408, 1, c, d));
        chk("R3 right CRC-32 DATA_W=32",   o_r32,          ref_serial(32, 32, 32'hEDB88320, 1, c, d));
    endtask

    initial begin
        automatic string msg = "123456789";
        automatic logic [15:0] c16;

        // Combinational cores: corner patterns, then pseudo-random ones
        core_round(32'h0, 32'h0);
        core_round(32'hFFFFFFFF, 32'h0);
        core_round(32'h0, 32'hFFFFFFFF);
        core_round(32'h80000001, 32'h00000001);
        for (int k = 0; k < 24; k++) core_round($urandom, $urandom);

        // R4: left 16-bit known answer, seed FFFF over "123456789"
        c16 = 16'hFFFF;
        for (int k = 0; k < 9; k++) begin
            cin = {16'd0, c16};
            din = {24'd0, msg[k]};
            #1;
            c16 = o_l16;
        end
        chk("R4 left CRC-16 known answer", {16'd0, c16}, 32'h29B1);

        // Registered unit
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk("R5 value after reset", crc_o, D_INIT);

        beat(0, 1, 8'h00);
        beat(0, 1, 8'hA5);
        beat(0, 0, 8'h3C);            // R7 hold, data ignored
        beat(0, 0, 8'hFF);            // R7 hold
        beat(0, 1, 8'h5A);
        beat(1, 1, 8'h77);            // R6 init wins over valid
        beat(0, 1, 8'h12);
        for (int k = 0; k < 12; k++) beat(0, ($urandom % 3) != 0, 8'($urandom));
        beat(1, 0, 8'h00);

        // R9 known answer on the raw register
        for (int k = 0; k < 9; k++) beat(0, 1, msg[k]);
        beat(0, 0, 8'h00);
        @(negedge clk);
        drv_beat = 0;
        init_i = 0; valid_i = 0;
        @(negedge clk);
        @(negedge clk);
        chk("R9 raw register after 123456789", crc_o, 32'h340BC6D9);
        chk("R4 R9 inverted reflected CRC-32", crc_o ^ 32'hFFFFFFFF, 32'hCBF43926);
        chk("R8 scoreboard drained", 32'(exp_q.size()), 32'd0);

        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule